// File: doc/BRIEF.md
# Selectable Bit Clock and Frame Generator

This block produces the bit clock, the frame sync and the data-start strobe for a serial system interface when the device owns the interface timing. Every rate comes from one reference clock by integer division. A 3-bit code picks one of five bit rates: 256, 512, 1536, 2048 or 2560 kHz. Frames repeat at 8 kHz. The frame-sync output is high for the first bit period of each frame. The data-start output marks the first data bit, either at the frame-sync bit or one bit later.

The block drives the interface only when the interface-mode input selects the register-programmed mode (`mw_sel = 1`) and the master bit is set. In slave operation all outputs stay low. With `mw_sel = 0` the rate, format and master fields are ignored. An illegal setting raises an error flag and keeps the clock silent: the slowest rate with the fourth format, or one of the three unused rate codes.

New settings are taken into use only at a frame boundary, so a frame never has a short clock period or a short frame. Downstream shift logic can use the one-cycle tick as its bit enable.

Top module: `bclk_frame_gen`

## Requirements
- R1: Rate code 000/001/010/011/100 divides the reference by 120/60/20/15/12 (256/512/1536/2048/2560 kHz at 30.72 MHz). Each bit period starts with `bclk_out` high for floor(divisor/2) reference cycles, and `bclk_out` is low for the rest of the period.
- R2: A frame lasts 3840 reference cycles. `fsync` rises together with the first bit clock rise of a frame and stays high for exactly one bit period.
- R3: `data_start` is high for one bit period. With `cfg_ddm = 0` it starts at the frame's first bit period. With `cfg_ddm = 1` it starts one bit period later.
- R4: With format code `cfg_fmt = 11` (the fourth format), `cfg_ddm` has no effect and data starts at the first bit period.
- R5: With `mw_sel = 1` and `cfg_master = 0`, `bclk_out`, `bclk_tick`, `fsync`, `data_start` and `cfg_err` all stay low.
- R6: With `mw_sel = 0`, the rate code, the format and the master bit are ignored. No output is driven and `cfg_err` stays low, even for combinations that are otherwise illegal.
- R7: Rate code 000 together with `cfg_fmt = 11`, and rate codes 101, 110 and 111, are illegal in master operation. For these, `cfg_err` is high for the whole frame and the clock, sync and strobe outputs stay low.
- R8: A configuration change takes effect only at the next frame boundary. A change made inside a frame leaves that frame's clock count and its error flag unchanged.
- R9: During reset all outputs are low. The first frame boundary comes 3840 cycles after reset release, and until then the block is idle whatever its configuration inputs.
- R10: `bclk_tick` is a one-reference-cycle pulse in the cycle of each `bclk_out` rise, and it pulses at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (30.72 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| mw_sel | input | 1 | 1 = register-programmed interface mode, 0 = alternate mode where the fields are ignored |
| cfg_master | input | 1 | 1 = drive the interface clock, 0 = slave |
| cfg_fmt | input | 2 | Frame format code, 00 to 11 for formats one to four |
| cfg_clk_sel | input | 3 | Bit rate code |
| cfg_ddm | input | 1 | 1 = delayed data start |
| bclk_out | output | 1 | Generated bit clock |
| bclk_tick | output | 1 | One-cycle pulse at each bit clock rise |
| fsync | output | 1 | Frame sync, one bit period wide |
| data_start | output | 1 | First-data-bit strobe, one bit period wide |
| cfg_err | output | 1 | Illegal master configuration in use |

## Verification
The bench lines its frame windows up with its own count of cycles since reset release. A design that loaded new settings right away, instead of at the boundary, would show a mixed clock count in the frame where the rate changes mid-frame. The odd divisor of 15 is measured for its high time: a design that rounded the half period up, or that let the phase drift, would report a wrong total high time over the frame. Three cases are aimed at the gating of the error logic: the illegal slowest-rate/fourth-format pair, that same pair in the alternate interface mode, and the unused rate codes. A design that decoded the error before checking the mode, or that missed the unused codes, would raise the flag wrongly or run a clock. Delayed data in the fourth format must still start at bit zero, which catches a design that ignores the format when it decodes the data-start bit.

// File: rtl/bcf_pkg.sv
package bcf_pkg;

  localparam int unsigned SLOW_KHZ  = 256;
  localparam int unsigned RATE2_KHZ = 512;
  localparam int unsigned RATE3_KHZ = 1536;
  localparam int unsigned RATE4_KHZ = 2048;
  localparam int unsigned FAST_KHZ  = 2560;

  localparam logic [1:0] FMT_FOUR   = 2'b11;
  localparam logic [2:0] CODE_SLOW  = 3'd0;
  localparam logic [2:0] CODE_LAST  = 3'd4;

  // configuration taken into use at a frame boundary
  typedef struct packed {
    logic       run;
    logic       err;
    logic       delayed;
    logic [2:0] code;
  } live_cfg_t;

  // legality of a rate code against the frame format
  function automatic logic combo_legal(input logic [2:0] code, input logic [1:0] fmt);
    logic ok;
    ok = (code <= CODE_LAST);
    if (code == CODE_SLOW && fmt == FMT_FOUR) ok = 1'b0;
    return ok;
  endfunction

  // reference cycles per bit period; 0 for unused codes
  function automatic int unsigned div_of(input logic [2:0] code, input int unsigned ref_khz);
    case (code)
      3'd0:    return ref_khz / SLOW_KHZ;
      3'd1:    return ref_khz / RATE2_KHZ;
      3'd2:    return ref_khz / RATE3_KHZ;
      3'd3:    return ref_khz / RATE4_KHZ;
      3'd4:    return ref_khz / FAST_KHZ;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/bcf_frame_timer.sv
module bcf_frame_timer #(
  parameter int unsigned FRAME_LEN = 3840
) (
  input  logic clk,
  input  logic rst_n,
  output logic frame_wrap
);
  localparam int unsigned FRM_W = $clog2(FRAME_LEN);
  localparam logic [FRM_W-1:0] LAST = FRM_W'(FRAME_LEN - 1);

  logic [FRM_W-1:0] frm_q;

  assign frame_wrap = (frm_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)          frm_q <= '0;
    else if (frame_wrap) frm_q <= '0;
    else                 frm_q <= frm_q + FRM_W'(1);
  end

  AST_WRAP_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> !frame_wrap); // R2

endmodule

// File: rtl/bcf_cfg_latch.sv
module bcf_cfg_latch
  import bcf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       mw_sel,
  input  logic       cfg_master,
  input  logic [1:0] cfg_fmt,
  input  logic [2:0] cfg_clk_sel,
  input  logic       cfg_ddm,
  output live_cfg_t  live
);
  logic      drive;
  logic      legal;
  live_cfg_t nxt;

  always_comb begin
    drive       = mw_sel && cfg_master;
    legal       = combo_legal(cfg_clk_sel, cfg_fmt);
    nxt.run     = drive && legal;
    nxt.err     = drive && !legal;
    nxt.delayed = cfg_ddm && (cfg_fmt != FMT_FOUR);
    nxt.code    = cfg_clk_sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    live <= '0;
    else if (load) live <= nxt;
  end

  AST_ALT_MODE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !mw_sel) |=> (!live.err && !live.run)); // R6

  AST_SLAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mw_sel && !cfg_master) |=> (!live.err && !live.run)); // R5

endmodule

// File: rtl/bcf_bit_timer.sv
module bcf_bit_timer
  import bcf_pkg::*;
#(
  parameter int unsigned REF_KHZ = 30720,
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned BIT_W   = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic       delayed,
  input  logic [2:0] code,
  output logic       bclk_o,
  output logic       tick_o,
  output logic       fs_o,
  output logic       ds_o
);
  logic [DIV_W-1:0] div_v;
  logic [DIV_W-1:0] half_v;
  logic [DIV_W-1:0] ph_q;
  logic [BIT_W-1:0] bit_q;
  logic [BIT_W-1:0] ds_bit;
  logic             ph_last;

  assign div_v   = DIV_W'(div_of(code, REF_KHZ));
  assign half_v  = div_v >> 1;
  assign ph_last = (ph_q == (div_v - DIV_W'(1)));
  assign ds_bit  = delayed ? BIT_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) begin
      ph_q  <= '0;
      bit_q <= '0;
    end else if (ph_last) begin
      ph_q  <= '0;
      bit_q <= bit_q + BIT_W'(1);
    end else begin
      ph_q  <= ph_q + DIV_W'(1);
    end
  end

  assign bclk_o = run && (ph_q < half_v);
  assign tick_o = run && (ph_q == '0);
  assign fs_o   = run && (bit_q == '0);
  assign ds_o   = run && (bit_q == ds_bit);

  AST_TICK_MARKS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_o) |-> tick_o); // R10

  AST_DS_DELAYED_AFTER_FS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ds_o) && delayed) |-> $fell(fs_o)); // R3

  AST_DS_DIRECT_WITH_FS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ds_o) && !delayed) |-> fs_o); // R3

endmodule

// File: rtl/bclk_frame_gen.sv
module bclk_frame_gen
  import bcf_pkg::*;
#(
  parameter int unsigned REF_KHZ   = 30720,
  parameter int unsigned FRAME_KHZ = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mw_sel,
  input  logic       cfg_master,
  input  logic [1:0] cfg_fmt,
  input  logic [2:0] cfg_clk_sel,
  input  logic       cfg_ddm,
  output logic       bclk_out,
  output logic       bclk_tick,
  output logic       fsync,
  output logic       data_start,
  output logic       cfg_err
);
  localparam int unsigned FRAME_LEN = REF_KHZ / FRAME_KHZ;
  localparam int unsigned DIV_W     = $clog2(REF_KHZ / SLOW_KHZ + 1);
  localparam int unsigned BIT_W     = $clog2(FRAME_LEN / (REF_KHZ / FAST_KHZ) + 1);

  logic      frame_wrap;
  live_cfg_t live;

  bcf_frame_timer #(.FRAME_LEN(FRAME_LEN)) frame_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_wrap (frame_wrap)
  );

  bcf_cfg_latch cfg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (frame_wrap),
    .mw_sel      (mw_sel),
    .cfg_master  (cfg_master),
    .cfg_fmt     (cfg_fmt),
    .cfg_clk_sel (cfg_clk_sel),
    .cfg_ddm     (cfg_ddm),
    .live        (live)
  );

  bcf_bit_timer #(.REF_KHZ(REF_KHZ), .DIV_W(DIV_W), .BIT_W(BIT_W)) bit_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (frame_wrap),
    .run     (live.run),
    .delayed (live.delayed),
    .code    (live.code),
    .bclk_o  (bclk_out),
    .tick_o  (bclk_tick),
    .fs_o    (fsync),
    .ds_o    (data_start)
  );

  assign cfg_err = live.err;

  AST_ERR_SILENCES_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!bclk_out && !fsync && !data_start && !bclk_tick)); // R7

  AST_CFG_HOLDS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(live)); // R8

  AST_FSYNC_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> ((fsync == live.run) && (bclk_tick == live.run))); // R2

endmodule

// File: tb/bclk_frame_gen_tb_top.sv
module bclk_frame_gen_tb_top;
  localparam int FRAME = 3840;
  localparam int NONE  = 9999;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mw_sel, cfg_master, cfg_ddm;
  logic [1:0] cfg_fmt;
  logic [2:0] cfg_clk_sel;
  logic       bclk_out, bclk_tick, fsync, data_start, cfg_err;

  always #5 clk = ~clk;

  bclk_frame_gen dut_i (
    .clk(clk), .rst_n(rst_n), .mw_sel(mw_sel), .cfg_master(cfg_master),
    .cfg_fmt(cfg_fmt), .cfg_clk_sel(cfg_clk_sel), .cfg_ddm(cfg_ddm),
    .bclk_out(bclk_out), .bclk_tick(bclk_tick), .fsync(fsync),
    .data_start(data_start), .cfg_err(cfg_err)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  typedef struct packed {
    logic        mw;
    logic        ms;
    logic [1:0]  fmt;
    logic [2:0]  ck;
    logic        ddm;
    logic [15:0] rises;
    logic [15:0] fs_len;
    logic [15:0] ds_off;
    logic [15:0] hi;
    logic        err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,2'd0,3'd0,1'b0,16'd32 ,16'd120,16'd0   ,16'd1920,1'b0}, // R1 R3
    '{1'b1,1'b1,2'd0,3'd1,1'b1,16'd64 ,16'd60 ,16'd60  ,16'd1920,1'b0}, // R1 R3 delayed
    '{1'b1,1'b1,2'd1,3'd2,1'b0,16'd192,16'd20 ,16'd0   ,16'd1920,1'b0}, // R1
    '{1'b1,1'b1,2'd2,3'd3,1'b1,16'd256,16'd15 ,16'd15  ,16'd1792,1'b0}, // R1 odd divisor
    '{1'b1,1'b1,2'd3,3'd4,1'b1,16'd320,16'd12 ,16'd0   ,16'd1920,1'b0}, // R4
    '{1'b1,1'b1,2'd3,3'd0,1'b0,16'd0  ,16'd0  ,16'd9999,16'd0   ,1'b1}, // R7 slow+fmt4
    '{1'b1,1'b1,2'd0,3'd5,1'b0,16'd0  ,16'd0  ,16'd9999,16'd0   ,1'b1}, // R7 code 101
    '{1'b1,1'b1,2'd1,3'd7,1'b1,16'd0  ,16'd0  ,16'd9999,16'd0   ,1'b1}, // R7 code 111
    '{1'b1,1'b0,2'd0,3'd2,1'b0,16'd0  ,16'd0  ,16'd9999,16'd0   ,1'b0}, // R5 slave
    '{1'b0,1'b1,2'd3,3'd0,1'b1,16'd0  ,16'd0  ,16'd9999,16'd0   ,1'b0}, // R6 alt mode
    '{1'b1,1'b1,2'd3,3'd1,1'b1,16'd64 ,16'd60 ,16'd0   ,16'd1920,1'b0}, // R4
    '{1'b1,1'b1,2'd2,3'd0,1'b0,16'd32 ,16'd120,16'd0   ,16'd1920,1'b0}  // R1 slow+fmt3
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input vec_t v);
    mw_sel = v.mw; cfg_master = v.ms; cfg_fmt = v.fmt;
    cfg_clk_sel = v.ck; cfg_ddm = v.ddm;
  endtask

  task automatic to_frame_start();
    do @(negedge clk); while ((cyc % FRAME) != 0);
  endtask

  // samples one frame starting at the current negedge
  task automatic measure(output int rises, output int ticks, output int stray,
                         output int fs_n, output int fs_first, output int ds_n,
                         output int ds_first, output int hi_n, output int err_n);
    logic prev;
    prev = 1'b0;
    rises = 0; ticks = 0; stray = 0; fs_n = 0; fs_first = NONE;
    ds_n = 0; ds_first = NONE; hi_n = 0; err_n = 0;
    for (int i = 0; i < FRAME; i++) begin
      if (i != 0) @(negedge clk);
      if (bclk_out && !prev) rises++;
      if (bclk_tick) ticks++;
      if (bclk_tick && !(bclk_out && !prev)) stray++;
      if (bclk_out) hi_n++;
      if (fsync) begin fs_n++; if (fs_first == NONE) fs_first = i; end
      if (data_start) begin ds_n++; if (ds_first == NONE) ds_first = i; end
      if (cfg_err) err_n++;
      prev = bclk_out;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rises, ticks, stray, fs_n, fs_first, ds_n, ds_first, hi_n, err_n;
    rst_n = 1'b0;
    set_cfg(VECS[0]);
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 bclk in reset", int'(bclk_out), 0);
    chk("R9 fsync in reset", int'(fsync), 0);
    chk("R9 err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    // R9: idle through the first frame even with a legal master setting
    rises = 0; err_n = 0;
    do begin
      @(negedge clk);
      if (bclk_out || fsync || data_start) rises++;
      if (cfg_err) err_n++;
    end while ((cyc % FRAME) != FRAME - 1);
    chk("R9 activity before first boundary", rises, 0);
    chk("R9 err before first boundary", err_n, 0);

    for (int k = 0; k < NV; k++) begin
      set_cfg(VECS[k]);
      @(negedge clk);
      to_frame_start();
      measure(rises, ticks, stray, fs_n, fs_first, ds_n, ds_first, hi_n, err_n);
      chk($sformatf("R1 rises vec%0d", k), rises, int'(VECS[k].rises));
      chk($sformatf("R1 high time vec%0d", k), hi_n, int'(VECS[k].hi));
      chk($sformatf("R10 ticks vec%0d", k), ticks, int'(VECS[k].rises));
      chk($sformatf("R10 stray ticks vec%0d", k), stray, 0);
      chk($sformatf("R2 fsync width vec%0d", k), fs_n, int'(VECS[k].fs_len));
      chk($sformatf("R2 fsync start vec%0d", k), fs_first, (VECS[k].fs_len != 0) ? 0 : NONE);
      chk($sformatf("R3 data start vec%0d", k), ds_first, int'(VECS[k].ds_off));
      chk($sformatf("R3 data width vec%0d", k), ds_n, int'(VECS[k].fs_len));
      chk($sformatf("R7 err cycles vec%0d", k), err_n, VECS[k].err ? FRAME : 0);
    end

    // R8: mid-frame change of rate keeps the current frame intact
    set_cfg(VECS[0]);
    @(negedge clk);
    to_frame_start();
    rises = 0; err_n = 0;
    begin
      logic prev;
      prev = 1'b0;
      for (int i = 0; i < FRAME; i++) begin
        if (i != 0) @(negedge clk);
        if (bclk_out && !prev) rises++;
        if (cfg_err) err_n++;
        prev = bclk_out;
        if (i == 1000) cfg_clk_sel = 3'd4;
        if (i == 2000) cfg_fmt = 2'd3;
        if (i == 3000) cfg_clk_sel = 3'd6;
      end
    end
    chk("R8 rises in changed frame", rises, 32);
    chk("R8 err in changed frame", err_n, 0);
    // the last value (illegal code 110) applies at the boundary
    @(negedge clk);
    chk("R8 err after boundary", int'(cfg_err), 1);
    chk("R7 bclk after boundary", int'(bclk_out), 0);
    cfg_clk_sel = 3'd4;
    to_frame_start();
    measure(rises, ticks, stray, fs_n, fs_first, ds_n, ds_first, hi_n, err_n);
    chk("R8 rises next frame", rises, 320);
    chk("R4 data start fmt4", ds_first, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule